// File: doc/BRIEF.md
# Prioritized External Interrupt Arbiter

This block collects interrupt requests from one non-maskable pin and eight general request pins and decides which one, if any, the processor should take next. Every general pin can be sensed on a rising edge, a falling edge, a low level or a high level, and carries a 4-bit priority. The non-maskable pin is always edge-sensed, at the fixed top level 16, and its active edge can be chosen at run time.

On each clock the block picks the strongest pending request and compares it against the mask level and block flag that the processor reports. A successful accept is a one-cycle strobe carrying a source code and a 5-bit level. With the auto-mask option on, the block also proposes a new mask value for the processor to write back. Software programs polarity, sense modes, priorities, the pin-enable bits and the auto-mask option through a small write-only register port. Pending edge requests can be cleared through the same port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `acc_valid` and `mask_upd` are low, all registers are zero (falling NMI edge, pins disabled, auto-mask off, all priorities 0), and no accept occurs until a request arrives.
- R2: Register port, written when `cfg_we` is high. Address 0 is control: bit 0 selects the NMI rising edge when 1 and the falling edge when 0, bits 2:1 are the two pin-enable bits, and bit 3 is auto-mask. Address 1 holds the sense selects, 2 bits per pin, with pin n at bits 2n+1:2n. Address 2 holds the priorities, 4 bits per pin, with pin n at bits 4n+3:4n. A write to address 3 clears the pending edge request of every pin whose data bit is 1.
- R3: A pin request is accepted only when its priority is nonzero, the priority is strictly greater than `cpu_mask`, and `cpu_block` is low. A pin whose priority is 0 never produces an accept.
- R4: Among the requesting pins, the highest priority wins, and a tie goes to the lowest pin index. A pending NMI beats every pin. Source codes are 0 to 7 for pins and 8 for NMI. The reported level is the pin's priority, or 16 for NMI.
- R5: NMI is raised only by the edge that control bit 0 selects. It is accepted when `cpu_block` is low, or when `cpu_block` is high and `cpu_sleep` is high. Otherwise it stays pending.
- R6: Every write to the control register blanks NMI edge detection for the next 6 clock edges. An edge that falls in that window is lost.
- R7: Pins raise requests only while both pin-enable bits are 1. Otherwise they raise none, and their pending edge requests are dropped.
- R8: Sense encoding is 00 low level, 01 falling edge, 10 rising edge and 11 high level. An edge request stays pending until it is accepted or cleared through address 3.
- R9: A level-sensed request is not stored. If the pin returns inactive before the request is accepted, no accept follows.
- R10: With auto-mask on, every accept also pulses `mask_upd`, and `mask_new` is 15 for NMI or the pin's priority for a pin. With auto-mask off, `mask_upd` stays low and `mask_new` is 0.
- R11: Pins pass through a two-stage synchronizer. An edge driven before clock edge k gives `acc_valid` after edge k+2 when it is eligible. `acc_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| irq_pins | input | 8 | General interrupt request pins |
| cpu_mask | input | 4 | Processor's current mask level |
| cpu_block | input | 1 | Processor block flag |
| cpu_sleep | input | 1 | Processor is sleeping |
| acc_valid | output | 1 | One-cycle accept strobe |
| acc_src | output | 4 | Accepted source code (0-7 pin, 8 NMI) |
| acc_level | output | 5 | Accepted level (1-16) |
| mask_upd | output | 1 | Proposed mask write-back strobe |
| mask_new | output | 4 | Proposed new mask level |

## Verification
A corrupted pending latch shows up as an accept that should not happen, or as one that never comes, within three cycles of the processor lowering its block flag. A wrong blanking count moves the boundary between a lost NMI edge and an accepted one by one cycle, so edges are placed just inside and just outside the window. Arbitration faults change the order of source codes when several latched edges are released together. Because the bench model predicts every output on every clock, a fault is caught on the first cycle that it diverges.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_FALL = 2'b01,
    SNS_RISE = 2'b10,
    SNS_HIGH = 2'b11
  } sense_t;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_SENSE = 2'd1;
  localparam logic [1:0] REG_PRIO  = 2'd2;
  localparam logic [1:0] REG_CLEAR = 2'd3;

  localparam int CTL_NMI_RISE = 0;
  localparam int CTL_EN_LO    = 1;
  localparam int CTL_EN_HI    = 2;
  localparam int CTL_AUTO     = 3;
  localparam int CTL_W        = 4;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);

  logic [W-1:0] st1_q, st2_q, st3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
      st3_q <= '0;
    end else begin
      st1_q <= din;
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  assign q   = st2_q;
  assign q_d = st3_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int N      = 8,
  parameter int PW     = 4,
  parameter int DW     = 32,
  parameter int BLANK  = 6,
  localparam int CNT_W = $clog2(BLANK + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic            nmi_rise,
  output logic            mode_on,
  output logic            auto_mask,
  output logic [2*N-1:0]  sense,
  output logic [N*PW-1:0] prio,
  output logic [N-1:0]    clr,
  output logic            blank_act
);

  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic [2*N-1:0]   sense_q, sense_d;
  logic [N*PW-1:0]  prio_q, prio_d;
  logic [CNT_W-1:0] blank_q, blank_d;
  logic             wr_ctrl;

  assign wr_ctrl = we && (addr == REG_CTRL);

  always_comb begin
    ctrl_d  = ctrl_q;
    sense_d = sense_q;
    prio_d  = prio_q;
    if (wr_ctrl)                      ctrl_d  = wdata[CTL_W-1:0];
    if (we && (addr == REG_SENSE))    sense_d = wdata[2*N-1:0];
    if (we && (addr == REG_PRIO))     prio_d  = wdata[N*PW-1:0];
    if (wr_ctrl)                      blank_d = CNT_W'(BLANK);
    else if (blank_q != '0)           blank_d = blank_q - CNT_W'(1);
    else                              blank_d = blank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sense_q <= '0;
      prio_q  <= '0;
      blank_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      sense_q <= sense_d;
      prio_q  <= prio_d;
      blank_q <= blank_d;
    end
  end

  assign nmi_rise  = ctrl_q[CTL_NMI_RISE];
  assign mode_on   = ctrl_q[CTL_EN_LO] & ctrl_q[CTL_EN_HI];
  assign auto_mask = ctrl_q[CTL_AUTO];
  assign sense     = sense_q;
  assign prio      = prio_q;
  assign clr       = (we && (addr == REG_CLEAR)) ? wdata[N-1:0] : '0;
  assign blank_act = (blank_q != '0);

endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic       pin_sd,
  input  logic [1:0] sense,
  input  logic       mode_on,
  input  logic       clr,
  input  logic       take,
  output logic       req
);

  logic pend_q, pend_d;
  logic edge_now, lvl_type, lvl_hit;

  always_comb begin
    edge_now = 1'b0;
    lvl_type = 1'b0;
    lvl_hit  = 1'b0;
    unique case (sense_t'(sense))
      SNS_LOW:  begin lvl_type = 1'b1; lvl_hit = ~pin_s; end
      SNS_HIGH: begin lvl_type = 1'b1; lvl_hit = pin_s;  end
      SNS_FALL: edge_now = ~pin_s & pin_sd;
      SNS_RISE: edge_now = pin_s & ~pin_sd;
      default:  edge_now = 1'b0;
    endcase
    if (mode_on) pend_d = (pend_q | edge_now) & ~clr & ~take;
    else         pend_d = 1'b0;
    req = mode_on & (lvl_type ? lvl_hit : (pend_q | edge_now));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N       = 8,
  parameter int PW      = 4,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IDX_W-1:0] idx,
  output logic [PW-1:0]   lvl
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (prio[i*PW +: PW] > lvl)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        lvl   = prio[i*PW +: PW];
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_PINS    = 8,
  parameter int PRIO_W    = 4,
  parameter int DATA_W    = 32,
  parameter int BLANK_CYC = 6,
  localparam int SRC_W    = $clog2(N_PINS + 1),
  localparam int LVL_W    = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              nmi_pin,
  input  logic [N_PINS-1:0] irq_pins,
  input  logic [PRIO_W-1:0] cpu_mask,
  input  logic              cpu_block,
  input  logic              cpu_sleep,
  output logic              acc_valid,
  output logic [SRC_W-1:0]  acc_src,
  output logic [LVL_W-1:0]  acc_level,
  output logic              mask_upd,
  output logic [PRIO_W-1:0] mask_new
);

  localparam int IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 nmi_rise, mode_on, auto_mask, blank_act;
  logic [2*N_PINS-1:0]  sense;
  logic [N_PINS*PRIO_W-1:0] prio;
  logic [N_PINS-1:0]    clr, pin_s, pin_sd, pin_req, pin_take;
  logic                 nmi_s, nmi_sd, nmi_edge, nmi_req;
  logic                 nmi_pend_q, nmi_pend_d;
  logic                 pin_found;
  logic [IDX_W-1:0]     pin_idx;
  logic [PRIO_W-1:0]    pin_lvl;
  logic                 take_nmi, take_pin;
  logic                 acc_valid_q, acc_valid_d;
  logic [SRC_W-1:0]     acc_src_q, acc_src_d;
  logic [LVL_W-1:0]     acc_level_q, acc_level_d;
  logic                 mask_upd_q, mask_upd_d;
  logic [PRIO_W-1:0]    mask_new_q, mask_new_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_cfg_regs #(
    .N(N_PINS), .PW(PRIO_W), .DW(DATA_W), .BLANK(BLANK_CYC)
  ) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .nmi_rise(nmi_rise), .mode_on(mode_on),
    .auto_mask(auto_mask), .sense(sense), .prio(prio), .clr(clr),
    .blank_act(blank_act)
  );

  irq_sync #(.W(1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_int_n), .din(nmi_pin), .q(nmi_s), .q_d(nmi_sd)
  );

  irq_sync #(.W(N_PINS)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .din(irq_pins), .q(pin_s), .q_d(pin_sd)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    irq_pin_detect u_det (
      .clk(clk), .rst_n(rst_int_n), .pin_s(pin_s[g]), .pin_sd(pin_sd[g]),
      .sense(sense[2*g +: 2]), .mode_on(mode_on), .clr(clr[g]),
      .take(pin_take[g]), .req(pin_req[g])
    );
  end

  irq_arbiter #(.N(N_PINS), .PW(PRIO_W)) u_arb (
    .req(pin_req), .prio(prio), .found(pin_found), .idx(pin_idx), .lvl(pin_lvl)
  );

  always_comb begin
    nmi_edge   = ~blank_act & (nmi_rise ? (nmi_s & ~nmi_sd) : (~nmi_s & nmi_sd));
    nmi_req    = nmi_pend_q | nmi_edge;
    take_nmi   = ~acc_valid_q & nmi_req & (~cpu_block | cpu_sleep);
    take_pin   = ~acc_valid_q & ~take_nmi & pin_found & (pin_lvl > cpu_mask) & ~cpu_block;
    nmi_pend_d = nmi_req & ~take_nmi;

    pin_take = '0;
    if (take_pin) pin_take[pin_idx] = 1'b1;

    acc_valid_d = take_nmi | take_pin;
    acc_src_d   = '0;
    acc_level_d = '0;
    if (take_nmi) begin
      acc_src_d   = SRC_W'(N_PINS);
      acc_level_d = LVL_W'(2 ** PRIO_W);
    end else if (take_pin) begin
      acc_src_d   = SRC_W'(pin_idx);
      acc_level_d = LVL_W'(pin_lvl);
    end

    mask_upd_d = auto_mask & acc_valid_d;
    mask_new_d = '0;
    if (mask_upd_d) mask_new_d = take_nmi ? {PRIO_W{1'b1}} : pin_lvl;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      nmi_pend_q  <= 1'b0;
      acc_valid_q <= 1'b0;
      acc_src_q   <= '0;
      acc_level_q <= '0;
      mask_upd_q  <= 1'b0;
      mask_new_q  <= '0;
    end else begin
      nmi_pend_q  <= nmi_pend_d;
      acc_valid_q <= acc_valid_d;
      acc_src_q   <= acc_src_d;
      acc_level_q <= acc_level_d;
      mask_upd_q  <= mask_upd_d;
      mask_new_q  <= mask_new_d;
    end
  end

  assign acc_valid = acc_valid_q;
  assign acc_src   = acc_src_q;
  assign acc_level = acc_level_q;
  assign mask_upd  = mask_upd_q;
  assign mask_new  = mask_new_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_PINS = 8,
  parameter int PRIO_W = 4,
  localparam int SRC_W = $clog2(N_PINS + 1),
  localparam int LVL_W = PRIO_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [SRC_W-1:0]  acc_src,
  input logic [LVL_W-1:0]  acc_level,
  input logic              mask_upd,
  input logic [PRIO_W-1:0] mask_new,
  input logic [PRIO_W-1:0] cpu_mask,
  input logic              cpu_block,
  input logic              cpu_sleep,
  input logic              mode_on
);

  localparam logic [SRC_W-1:0] NMI_CODE = SRC_W'(N_PINS);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> !acc_valid); // R11

  AST_NMI_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_src == NMI_CODE) |-> acc_level == LVL_W'(2 ** PRIO_W)); // R4

  AST_PIN_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_src != NMI_CODE) |-> (acc_src < NMI_CODE && acc_level != '0)); // R3

  AST_PIN_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_src != NMI_CODE) |->
      (acc_level > LVL_W'($past(cpu_mask)) && !$past(cpu_block))); // R3

  AST_NMI_BLOCK_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_src == NMI_CODE) |-> (!$past(cpu_block) || $past(cpu_sleep))); // R5

  AST_PIN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_src != NMI_CODE) |-> $past(mode_on)); // R7

  AST_UPD_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mask_upd |-> acc_valid); // R10

  AST_NMI_MASK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_upd && acc_src == NMI_CODE) |-> mask_new == {PRIO_W{1'b1}}); // R10

  AST_PIN_MASK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_upd && acc_src != NMI_CODE) |-> LVL_W'(mask_new) == acc_level); // R10

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_PINS(N_PINS), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_src(acc_src),
  .acc_level(acc_level), .mask_upd(mask_upd), .mask_new(mask_new),
  .cpu_mask(cpu_mask), .cpu_block(cpu_block), .cpu_sleep(cpu_sleep),
  .mode_on(mode_on)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        nmi_pin = 1'b1;
  logic [7:0]  irq_pins = '0;
  logic [3:0]  cpu_mask = '0;
  logic        cpu_block = 1'b0;
  logic        cpu_sleep = 1'b0;
  logic        acc_valid;
  logic [3:0]  acc_src;
  logic [4:0]  acc_level;
  logic        mask_upd;
  logic [3:0]  mask_new;

  always #4 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .nmi_pin(nmi_pin), .irq_pins(irq_pins),
    .cpu_mask(cpu_mask), .cpu_block(cpu_block), .cpu_sleep(cpu_sleep),
    .acc_valid(acc_valid), .acc_src(acc_src), .acc_level(acc_level),
    .mask_upd(mask_upd), .mask_new(mask_new)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   sh_ctrl, sh_sense, sh_prio, m_blank;
  bit   m_n1, m_n2, m_n3, m_npend;
  bit   m_p1 [8], m_p2 [8], m_p3 [8], m_pend [8];
  bit   exp_acc, exp_upd;
  int   exp_src, exp_lvl, exp_new;

  always @(posedge clk) begin
    if (!rst_n) begin
      sh_ctrl = 0; sh_sense = 0; sh_prio = 0; m_blank = 0;
      m_n1 = 0; m_n2 = 0; m_n3 = 0; m_npend = 0;
      foreach (m_p1[i]) begin m_p1[i] = 0; m_p2[i] = 0; m_p3[i] = 0; m_pend[i] = 0; end
      exp_acc = 0; exp_upd = 0; exp_src = 0; exp_lvl = 0; exp_new = 0;
    end else begin
      bit mode, rise, auto, nedge, nreq, tn, tp;
      bit ed [8];
      int best, bl;
      mode = ((sh_ctrl >> 1) & 3) == 3;
      rise = sh_ctrl[0];
      auto = sh_ctrl[3];
      nedge = (m_blank == 0) && (rise ? (m_n2 && !m_n3) : (!m_n2 && m_n3));
      nreq = m_npend || nedge;
      best = -1; bl = 0;
      for (int i = 0; i < 8; i++) begin
        int sn, pr;
        bit rq;
        sn = (sh_sense >> (2*i)) & 3;
        pr = (sh_prio >> (4*i)) & 15;
        ed[i] = (sn == 1) ? (!m_p2[i] && m_p3[i]) : (sn == 2) ? (m_p2[i] && !m_p3[i]) : 0;
        if (sn == 0)      rq = !m_p2[i];
        else if (sn == 3) rq = m_p2[i];
        else              rq = m_pend[i] || ed[i];
        rq = rq && mode;
        if (rq && pr > bl) begin best = i; bl = pr; end
      end
      tn = !exp_acc && nreq && (!cpu_block || cpu_sleep);
      tp = !exp_acc && !tn && best >= 0 && bl > cpu_mask && !cpu_block;
      for (int i = 0; i < 8; i++) begin
        bit cl;
        cl = cfg_we && cfg_addr == 3 && cfg_wdata[i];
        m_pend[i] = mode && (m_pend[i] || ed[i]) && !cl && !(tp && best == i);
      end
      m_npend = nreq && !tn;
      exp_acc = tn || tp;
      exp_src = tn ? 8 : (tp ? best : 0);
      exp_lvl = tn ? 16 : (tp ? bl : 0);
      exp_upd = auto && (tn || tp);
      exp_new = exp_upd ? (tn ? 15 : bl) : 0;
      if (cfg_we && cfg_addr == 0) m_blank = 6;
      else if (m_blank > 0)        m_blank--;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: sh_ctrl  = int'(cfg_wdata[3:0]);
          2'd1: sh_sense = int'(cfg_wdata[15:0]);
          2'd2: sh_prio  = int'(cfg_wdata);
          default: ;
        endcase
      end
      m_n3 = m_n2; m_n2 = m_n1; m_n1 = nmi_pin;
      for (int i = 0; i < 8; i++) begin
        m_p3[i] = m_p2[i]; m_p2[i] = m_p1[i]; m_p1[i] = irq_pins[i];
      end
    end
  end

  // ---------------- per-cycle comparison and accept log ----------------
  int acc_cnt, consec, last_src, last_lvl, last_new;
  bit last_upd, prev_acc;
  int src_log [16];

  always @(negedge clk) begin
    int act, exv;
    act = {acc_valid, acc_src, acc_level, mask_upd, mask_new};
    exv = {exp_acc, 4'(exp_src), 5'(exp_lvl), exp_upd, 4'(exp_new)};
    chk(act == exv, cur_req, act, exv);
    if (acc_valid) begin
      if (acc_cnt < 16) src_log[acc_cnt] = int'(acc_src);
      acc_cnt++;
      last_src = int'(acc_src); last_lvl = int'(acc_level);
      last_upd = mask_upd; last_new = int'(mask_new);
      if (prev_acc) consec++;
    end
    prev_acc = acc_valid;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_log;
    acc_cnt = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    acc_cnt = 0; consec = 0; prev_acc = 0;
    cyc(3);
    cur_req = "R1";
    chk(acc_valid == 0 && mask_upd == 0, "R1", int'(acc_valid), 0);
    rst_n = 1'b1;
    cyc(10);
    chk(acc_cnt == 0, "R1", acc_cnt, 0);

    // R7: pins silent unless both enable bits are set
    cur_req = "R7";
    cfg_write(2'd1, 32'h0000_0003);       // pin0 high level
    cfg_write(2'd2, 32'h0000_0005);       // pin0 priority 5
    irq_pins[0] = 1'b1;
    cfg_write(2'd0, 32'h2);               // only one enable bit
    clear_log(); cyc(8);
    chk(acc_cnt == 0, "R7", acc_cnt, 0);

    // R2/R8: high-level pin accepted once enabled
    cur_req = "R8";
    cfg_write(2'd0, 32'h6);
    cyc(8);
    chk(acc_cnt >= 3, "R8", acc_cnt, 3);
    chk(last_src == 0 && last_lvl == 5, "R2", last_src * 100 + last_lvl, 5);

    // R3: mask level comparison and zero priority
    cur_req = "R3";
    cpu_mask = 4'd5; cyc(3); clear_log(); cyc(8);
    chk(acc_cnt == 0, "R3", acc_cnt, 0);
    cpu_mask = 4'd4; clear_log(); cyc(8);
    chk(acc_cnt > 0, "R3", acc_cnt, 1);
    cpu_mask = 4'd0;
    cfg_write(2'd2, 32'h0); cyc(2); clear_log(); cyc(8);
    chk(acc_cnt == 0, "R3", acc_cnt, 0);
    cfg_write(2'd2, 32'h5);

    // R9: level request not latched
    cur_req = "R9";
    irq_pins[0] = 1'b0; cpu_block = 1'b1; cyc(5);
    irq_pins[0] = 1'b1; cyc(6); irq_pins[0] = 1'b0; cyc(5);
    clear_log(); cpu_block = 1'b0; cyc(6);
    chk(acc_cnt == 0, "R9", acc_cnt, 0);

    // R8: rising and falling edges latched, write-one-to-clear
    cur_req = "R8";
    cfg_write(2'd1, 32'h0000_0027);       // pin0 high, pin1 fall, pin2 rise
    cfg_write(2'd2, 32'h0000_0735);       // pin0 5, pin1 3, pin2 7
    cpu_block = 1'b1; irq_pins[2] = 1'b1; cyc(5);
    clear_log(); cpu_block = 1'b0; cyc(5);
    chk(acc_cnt == 1 && last_src == 2 && last_lvl == 7, "R8", last_src * 100 + last_lvl, 207);
    irq_pins[2] = 1'b0; cyc(3);
    cpu_block = 1'b1; irq_pins[2] = 1'b1; cyc(5);
    cfg_write(2'd3, 32'h4);
    clear_log(); cpu_block = 1'b0; cyc(6);
    chk(acc_cnt == 0, "R8", acc_cnt, 0);
    irq_pins[2] = 1'b0;
    irq_pins[1] = 1'b1; clear_log(); cyc(5);
    chk(acc_cnt == 0, "R8", acc_cnt, 0);
    irq_pins[1] = 1'b0; cyc(5);
    chk(acc_cnt == 1 && last_src == 1 && last_lvl == 3, "R8", last_src * 100 + last_lvl, 103);

    // R4: highest priority first, ties to lowest index
    cur_req = "R4";
    cfg_write(2'd1, 32'h0000_0AA7);       // pins 3,4,5 rising
    cfg_write(2'd2, 32'h009B_9735);       // pin3 9, pin4 11, pin5 9
    cpu_block = 1'b1; irq_pins[5:3] = 3'b111; cyc(5);
    clear_log(); cpu_block = 1'b0; cyc(10);
    chk(acc_cnt == 3, "R4", acc_cnt, 3);
    chk(src_log[0] == 4, "R4", src_log[0], 4);
    chk(src_log[1] == 3, "R4", src_log[1], 3);
    chk(src_log[2] == 5, "R4", src_log[2], 5);
    irq_pins[5:3] = 3'b000;

    // R5: falling NMI held by block, taken in sleep, beats a pin
    cur_req = "R5";
    cpu_block = 1'b1; cyc(3);
    irq_pins[2] = 1'b1; nmi_pin = 1'b0; clear_log(); cyc(6);
    chk(acc_cnt == 0, "R5", acc_cnt, 0);
    cpu_sleep = 1'b1; cyc(4);
    chk(acc_cnt == 1 && last_src == 8 && last_lvl == 16, "R5", last_src * 100 + last_lvl, 816);
    cpu_sleep = 1'b0; cpu_block = 1'b0; cyc(4);
    chk(acc_cnt == 2 && last_src == 2, "R4", last_src, 2);
    irq_pins[2] = 1'b0;
    nmi_pin = 1'b1; clear_log(); cyc(6);
    chk(acc_cnt == 0, "R5", acc_cnt, 0);

    // R6: blanking window after a control write (rising select)
    cur_req = "R6";
    nmi_pin = 1'b0; cyc(3);
    cfg_write(2'd0, 32'h7); cyc(3);
    nmi_pin = 1'b1; clear_log(); cyc(10);
    chk(acc_cnt == 0, "R6", acc_cnt, 0);
    nmi_pin = 1'b0; cyc(5);
    cfg_write(2'd0, 32'h7); cyc(4);
    nmi_pin = 1'b1; clear_log(); cyc(10);
    chk(acc_cnt == 1 && last_src == 8, "R6", acc_cnt, 1);

    // R10: auto-mask proposals
    cur_req = "R10";
    nmi_pin = 1'b0; cyc(3);
    cfg_write(2'd0, 32'hF); cyc(8);
    nmi_pin = 1'b1; clear_log(); cyc(6);
    chk(acc_cnt == 1 && last_upd && last_new == 15, "R10", last_new, 15);
    irq_pins[2] = 1'b1; clear_log(); cyc(6);
    chk(acc_cnt == 1 && last_upd && last_new == 7, "R10", last_new, 7);
    irq_pins[2] = 1'b0;
    cfg_write(2'd0, 32'h7); cyc(3);
    irq_pins[2] = 1'b1; clear_log(); cyc(6);
    chk(acc_cnt == 1 && !last_upd && last_new == 0, "R10", int'(last_upd), 0);
    irq_pins[2] = 1'b0; cyc(4);

    // R11: three-edge latency and single-cycle strobes
    cur_req = "R11";
    lat = 0;
    irq_pins[2] = 1'b1;
    while (!acc_valid && lat < 10) begin
      @(negedge clk); lat++;
    end
    chk(lat == 3, "R11", lat, 3);
    irq_pins[2] = 1'b0;
    irq_pins[0] = 1'b1; cyc(12); irq_pins[0] = 1'b0; cyc(5);
    chk(consec == 0, "R11", consec, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule